// File: doc/BRIEF.md
# Paged Handshake Bus Slave Endpoint

This block is the peripheral side of an 8-bit shared bus on which a master sends a two-byte address and then one data byte over the same eight lines. Each byte is framed by a four-phase handshake. The master pulls an active-low address strobe (`asel_n`) for each address byte, or an active-low data strobe (`dsel_n`) for the data byte. The endpoint answers by pulling the open-drain acknowledge line low. It releases the line after the master has lifted the strobe. A direction line (`mrd`) says whether the data byte flows towards the master (read) or away from it (write).

The endpoint answers only for transactions whose first address byte, the most significant one, equals its configured page value. Otherwise it stays silent for the low address byte and the data byte as well. The low address byte is presented on a local register interface. A write byte arrives on that interface with a one-clock write strobe. A read byte is fetched after a one-clock read strobe and is driven onto the bus lines before the acknowledge.

The strobes and direction line pass through synchronizers. A run-time delay of 0 to 255 clocks can be inserted before every acknowledge, so a fast implementation can stand in for a slow responder. The acknowledge output is a pull-down enable, and the bus lines use an output enable. The block never drives either line high itself.

Top module: `mxbus_endpoint`

## Requirements
- R1: While reset is asserted, including an asynchronous reset in the middle of a handshake, `ack_pull`, `cd_oe`, `loc_wr` and `loc_rd` are 0. After reset the endpoint expects a high address byte next.
- R2: When the first address byte equals `page_id`, the endpoint acknowledges that byte, the following low address byte and the following data byte.
- R3: When the first address byte differs from `page_id`, no acknowledge, no bus drive and no local strobe occurs for that byte, the low address byte or the data byte. The next transaction is decoded normally.
- R4: On an acknowledged transaction, `loc_addr` equals the low address byte. It holds that value from the capture of that byte until the next accepted low address byte.
- R5: On an acknowledged write (`mrd`=0 in the data phase), `loc_wr` is high for exactly one clock with `loc_wdata` equal to the byte on `cd_i`. There is exactly one such pulse per write and none on reads.
- R6: On an acknowledged read (`mrd`=1), `loc_rd` is high for exactly one clock, and `loc_rdata` is sampled in that clock. The sampled byte is on `cd_o` with `cd_oe`=1 before and while `ack_pull` is 1, and it stays stable while driven.
- R7: `ack_pull` stays 1 while the strobe is held. Counting rising edges after the master lifts the strobe, `ack_pull` falls after edge 3 for address and write bytes. On a read, `cd_oe` falls after edge 3 and `ack_pull` falls after edge 4, so the bus is released before the acknowledge.
- R8: Counting rising edges after a strobe falls, `ack_pull` first reads 1 after edge `resp_dly`+5 for address and write bytes, and after edge `resp_dly`+6 for read data bytes.
- R9: `cd_oe` is 1 only in the data phase of an acknowledged read with `mrd`=1. It is never 1 during address bytes, writes or unclaimed transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_id | input | 8 | High address byte this endpoint answers to |
| resp_dly | input | 8 | Extra clocks inserted before each acknowledge |
| asel_n | input | 1 | Address strobe, active low, asynchronous |
| dsel_n | input | 1 | Data strobe, active low, asynchronous |
| mrd | input | 1 | 1 = data flows from endpoint to master |
| cd_i | input | 8 | Bus lines as received |
| cd_o | output | 8 | Read byte for the bus lines |
| cd_oe | output | 1 | Output enable for the bus lines |
| ack_pull | output | 1 | 1 = pull acknowledge low; 0 = release |
| loc_addr | output | 8 | Low address byte to the local registers |
| loc_wdata | output | 8 | Write byte to the local registers |
| loc_wr | output | 1 | One-clock write strobe |
| loc_rd | output | 1 | One-clock read strobe |
| loc_rdata | input | 8 | Read byte from the local registers, sampled while loc_rd is 1 |

## Verification
The bench builds the endpoint with its default parameters: an 8-bit bus, an 8-bit delay counter and two synchronizer stages. With these defaults the full delay range is reachable, so a 255-clock acknowledge delay is measured against the 260-edge latency next to the zero-delay and small-delay cases. Two flop stages fix the edge counts of R7 and R8, and the bench counts acknowledge and release timing exactly. The transactions alternate hits and misses, so resynchronization after an unclaimed transaction is exercised, along with an asynchronous reset while the acknowledge is held.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_RLOAD,
    ST_WAIT,
    ST_ACK,
    ST_RREL,
    ST_IGNORE
  } ep_state_t;

  typedef enum logic [1:0] {
    SQ_HI,
    SQ_LO,
    SQ_DATA
  } seq_t;

endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mxb_delay.sv
module mxb_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
  import mxb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          asel_s,
  input  logic          dsel_s,
  input  logic          mrd_s,
  input  logic [DW-1:0] cd_i,
  input  logic [DW-1:0] page_id,
  input  logic [DW-1:0] loc_rdata,
  input  logic          dly_done,
  output logic          dly_load,
  output logic          ack_pull,
  output logic          cd_oe,
  output logic [DW-1:0] cd_o,
  output logic [DW-1:0] loc_addr,
  output logic [DW-1:0] loc_wdata,
  output logic          loc_wr,
  output logic          loc_rd
);

  ep_state_t     state_q, state_d;
  seq_t          seq_q, seq_d;
  logic          hit_q, hit_d;
  logic          rd_q, rd_d;
  logic          isaddr_q, isaddr_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          wr_q, wr_d;
  logic          rdp_q, rdp_d;
  logic          strobe;
  logic          page_eq;

  assign strobe  = isaddr_q ? asel_s : dsel_s;
  assign page_eq = (cd_i == page_id);

  always_comb begin
    state_d  = state_q;
    seq_d    = seq_q;
    hit_d    = hit_q;
    rd_d     = rd_q;
    isaddr_d = isaddr_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    wr_d     = 1'b0;
    rdp_d    = 1'b0;
    dly_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (asel_s) begin
          isaddr_d = 1'b1;
          state_d  = ST_SAMPLE;
        end else if (dsel_s) begin
          isaddr_d = 1'b0;
          state_d  = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        rd_d = 1'b0;
        if (isaddr_q) begin
          if (seq_q == SQ_LO) begin
            seq_d = SQ_DATA;
            if (hit_q) begin
              addr_d   = cd_i;
              dly_load = 1'b1;
              state_d  = ST_WAIT;
            end else begin
              state_d  = ST_IGNORE;
            end
          end else begin
            seq_d = SQ_LO;
            hit_d = page_eq;
            if (page_eq) begin
              dly_load = 1'b1;
              state_d  = ST_WAIT;
            end else begin
              state_d  = ST_IGNORE;
            end
          end
        end else begin
          if (seq_q == SQ_DATA) seq_d = SQ_HI;
          hit_d = 1'b0;
          if ((seq_q == SQ_DATA) && hit_q) begin
            if (mrd_s) begin
              rd_d    = 1'b1;
              rdp_d   = 1'b1;
              state_d = ST_RLOAD;
            end else begin
              wdata_d  = cd_i;
              wr_d     = 1'b1;
              dly_load = 1'b1;
              state_d  = ST_WAIT;
            end
          end else begin
            state_d = ST_IGNORE;
          end
        end
      end
      ST_RLOAD: begin
        rdata_d  = loc_rdata;
        dly_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (dly_done) state_d = ST_ACK;
      end
      ST_ACK: begin
        if (!strobe) state_d = rd_q ? ST_RREL : ST_IDLE;
      end
      ST_RREL: begin
        rd_d    = 1'b0;
        state_d = ST_IDLE;
      end
      ST_IGNORE: begin
        if (!strobe) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      seq_q    <= SQ_HI;
      hit_q    <= 1'b0;
      rd_q     <= 1'b0;
      isaddr_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      wr_q     <= 1'b0;
      rdp_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      seq_q    <= seq_d;
      hit_q    <= hit_d;
      rd_q     <= rd_d;
      isaddr_q <= isaddr_d;
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
      rdata_q  <= rdata_d;
      wr_q     <= wr_d;
      rdp_q    <= rdp_d;
    end
  end

  assign ack_pull  = (state_q == ST_ACK) || (state_q == ST_RREL);
  assign cd_oe     = rd_q && ((state_q == ST_WAIT) || (state_q == ST_ACK));
  assign cd_o      = rdata_q;
  assign loc_addr  = addr_q;
  assign loc_wdata = wdata_q;
  assign loc_wr    = wr_q;
  assign loc_rd    = rdp_q;

endmodule

// File: rtl/mxbus_endpoint.sv
module mxbus_endpoint #(
  parameter int DW          = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    page_id,
  input  logic [CNT_W-1:0] resp_dly,
  input  logic             asel_n,
  input  logic             dsel_n,
  input  logic             mrd,
  input  logic [DW-1:0]    cd_i,
  output logic [DW-1:0]    cd_o,
  output logic             cd_oe,
  output logic             ack_pull,
  output logic [DW-1:0]    loc_addr,
  output logic [DW-1:0]    loc_wdata,
  output logic             loc_wr,
  output logic             loc_rd,
  input  logic [DW-1:0]    loc_rdata
);

  localparam int CTL_W = 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_sync;
  logic             asel_s;
  logic             dsel_s;
  logic             mrd_s;
  logic             dly_load;
  logic             dly_done;

  // reset: asserted at once, removed on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign ctl_raw = {mrd, ~dsel_n, ~asel_n};

  mxb_sync #(
    .WIDTH   (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ('0)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (ctl_raw),
    .q     (ctl_sync)
  );

  assign asel_s = ctl_sync[0];
  assign dsel_s = ctl_sync[1];
  assign mrd_s  = ctl_sync[2];

  mxb_delay #(
    .CNT_W (CNT_W)
  ) i_delay (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (dly_load),
    .load_val (resp_dly),
    .done     (dly_done)
  );

  mxb_ctrl #(
    .DW (DW)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .asel_s    (asel_s),
    .dsel_s    (dsel_s),
    .mrd_s     (mrd_s),
    .cd_i      (cd_i),
    .page_id   (page_id),
    .loc_rdata (loc_rdata),
    .dly_done  (dly_done),
    .dly_load  (dly_load),
    .ack_pull  (ack_pull),
    .cd_oe     (cd_oe),
    .cd_o      (cd_o),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_wr    (loc_wr),
    .loc_rd    (loc_rd)
  );

endmodule

// File: rtl/mxb_endpoint_chk.sv
module mxb_endpoint_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          asel_s,
  input logic          dsel_s,
  input logic          mrd_s,
  input logic          ack_pull,
  input logic          cd_oe,
  input logic [DW-1:0] cd_o,
  input logic          loc_wr,
  input logic          loc_rd
);

  logic strobe_any;
  assign strobe_any = asel_s || dsel_s;

  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |=> !loc_wr);

  a_r5_wr_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |-> !cd_oe);

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rd |=> !loc_rd);

  a_r6_cd_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_oe && $past(cd_oe)) |-> $stable(cd_o));

  a_r9_oe_needs_mrd: assert property (@(posedge clk) disable iff (!rst_n)
    cd_oe |-> mrd_s);

  a_r7_cd_off_before_ack_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_pull) |-> !$past(cd_oe));

  a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pull && strobe_any && $past(strobe_any)) |=> ack_pull);

  a_r2_ack_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> strobe_any);

endmodule

bind mxbus_endpoint mxb_endpoint_chk #(.DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .asel_s   (asel_s),
  .dsel_s   (dsel_s),
  .mrd_s    (mrd_s),
  .ack_pull (ack_pull),
  .cd_oe    (cd_oe),
  .cd_o     (cd_o),
  .loc_wr   (loc_wr),
  .loc_rd   (loc_rd)
);

// File: tb/test_mxbus_endpoint.sv
`timescale 1ns/1ps
module test_mxbus_endpoint;

  localparam logic [7:0] PAGE = 8'hC3;
  localparam int NVEC = 8;
  // {high addr, low addr, read flag, write data, response delay}
  localparam logic [39:0] VEC [NVEC] = '{
    40'hC3_10_00_A5_00,
    40'hC3_11_01_00_00,
    40'h7E_12_00_33_00,
    40'hC3_FF_00_5A_03,
    40'h12_20_01_00_02,
    40'hC3_00_01_00_07,
    40'hC3_80_00_FF_01,
    40'hC3_42_01_00_10
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] page_id;
  logic [7:0] resp_dly;
  logic       asel_n, dsel_n, mrd;
  logic [7:0] cd_m;
  logic [7:0] cd_o;
  logic       cd_oe, ack_pull;
  logic [7:0] loc_addr, loc_wdata, loc_rdata;
  logic       loc_wr, loc_rd;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  wr_cnt = 0;
  int  rd_cnt = 0;
  logic [7:0] last_wdata = '0;
  logic [7:0] last_waddr = '0;
  bit  oe_seen = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  assign loc_rdata = loc_addr ^ 8'h5A;

  mxbus_endpoint i_mxbus_endpoint (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_id   (page_id),
    .resp_dly  (resp_dly),
    .asel_n    (asel_n),
    .dsel_n    (dsel_n),
    .mrd       (mrd),
    .cd_i      (cd_m),
    .cd_o      (cd_o),
    .cd_oe     (cd_oe),
    .ack_pull  (ack_pull),
    .loc_addr  (loc_addr),
    .loc_wdata (loc_wdata),
    .loc_wr    (loc_wr),
    .loc_rd    (loc_rd),
    .loc_rdata (loc_rdata)
  );

  always @(negedge clk) begin
    if (loc_wr) begin
      wr_cnt++;
      last_wdata = loc_wdata;
      last_waddr = loc_addr;
    end
    if (loc_rd) rd_cnt++;
    if (cd_oe)  oe_seen = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one byte handshake, entered and left at a falling clock edge
  task automatic xfer(input bit isaddr, input logic [7:0] val, input bit exp_ack,
                      input int exp_lat, input bit rdph, input logic [7:0] exp_cd);
    int lat = 0;
    bit seen = 1'b0;
    int oe_off = -1;
    int ack_off = -1;
    cd_m = val;
    if (isaddr) asel_n = 1'b0;
    else        dsel_n = 1'b0;
    while (!seen && lat < exp_lat + 20) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (ack_pull) seen = 1'b1;
    end
    if (exp_ack) begin
      check(seen && lat == exp_lat, "R8 ack latency", lat, exp_lat);
      if (rdph) check(cd_oe && cd_o == exp_cd, "R6 read byte on bus", int'(cd_o), int'(exp_cd));
    end else begin
      check(!seen, "R3 silent on miss", int'(seen), 0);
    end
    asel_n = 1'b1;
    dsel_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!cd_oe && oe_off < 0)    oe_off = k;
      if (!ack_pull && ack_off < 0) ack_off = k;
    end
    if (exp_ack) begin
      check(ack_off == (rdph ? 4 : 3), "R7 ack release", ack_off, rdph ? 4 : 3);
      if (rdph) check(oe_off == 3, "R7 bus release first", oe_off, 3);
    end
    cd_m = '0;
  endtask

  task automatic run(input logic [7:0] hi, input logic [7:0] lo, input bit rd,
                     input logic [7:0] wd, input logic [7:0] dly);
    bit hit = (hi == PAGE);
    int w0 = wr_cnt;
    int r0 = rd_cnt;
    resp_dly = dly;
    oe_seen  = 1'b0;
    mrd      = rd;
    xfer(1'b1, hi, hit, 5 + int'(dly), 1'b0, 8'h00);
    xfer(1'b1, lo, hit, 5 + int'(dly), 1'b0, 8'h00);
    xfer(1'b0, rd ? 8'h00 : wd, hit, (rd ? 6 : 5) + int'(dly), rd, lo ^ 8'h5A);
    mrd = 1'b0;
    @(negedge clk);
    if (hit) begin
      check(loc_addr == lo, "R4 local address", int'(loc_addr), int'(lo));
      if (rd) begin
        check(rd_cnt == r0 + 1, "R6 one read strobe", rd_cnt - r0, 1);
        check(wr_cnt == w0, "R5 no write on read", wr_cnt - w0, 0);
      end else begin
        check(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt - w0, 1);
        check(last_wdata == wd && last_waddr == lo, "R5 write byte", int'(last_wdata), int'(wd));
        check(!oe_seen, "R9 no drive on write", int'(oe_seen), 0);
      end
    end else begin
      check(wr_cnt == w0 && rd_cnt == r0, "R3 no local strobe on miss",
            (wr_cnt - w0) + (rd_cnt - r0), 0);
      check(!oe_seen, "R9 no drive on miss", int'(oe_seen), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    page_id  = PAGE;
    resp_dly = '0;
    asel_n   = 1'b1;
    dsel_n   = 1'b1;
    mrd      = 1'b0;
    cd_m     = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!ack_pull && !cd_oe && !loc_wr && !loc_rd, "R1 outputs in reset",
          int'({ack_pull, cd_oe, loc_wr, loc_rd}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!ack_pull && !cd_oe, "R1 quiet after reset", int'({ack_pull, cd_oe}), 0);

    // table walk: R2 hits, R3 misses and resync, R4..R9
    for (int v = 0; v < NVEC; v++) begin
      run(VEC[v][39:32], VEC[v][31:24], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R8 longest delay
    run(PAGE, 8'h77, 1'b0, 8'h3C, 8'hFF);

    // R1 asynchronous reset while acknowledge is held
    resp_dly = '0;
    mrd      = 1'b0;
    cd_m     = PAGE;
    asel_n   = 1'b0;
    repeat (8) @(negedge clk);
    check(ack_pull, "R2 ack before reset", int'(ack_pull), 1);
    rst_n = 1'b0;
    #1;
    check(!ack_pull && !cd_oe, "R1 async reset drops ack", int'(ack_pull), 0);
    @(negedge clk);
    asel_n = 1'b1;
    cd_m   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1/R2 sequence restarts at the high byte after reset
    run(PAGE, 8'h05, 1'b1, 8'h00, 8'h02);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule